// File: doc/BRIEF.md
# Banked Two-Wire Serial Memory Slave

This block is a target-only memory on a two-wire serial bus with an open-drain data line. It holds 64K bytes split into two banks of 32K. A fast system clock oversamples the bus clock and data lines. From those samples the block finds Start and Stop conditions, shifts data bits, and answers in the acknowledge slot. A master opens each transfer with a device byte. That byte names the device through two strap pins and also picks the bank. For a write, the master then sends a two-byte location followed by data. For a read, the data comes from the internal address counter.

Every write reaches storage within a few system clocks of its acknowledge. A new transfer can therefore start straight after the Stop, and the device never refuses one because it is busy. The data line is modelled as a pull-down enable: while `sda_oe` is high, the block pulls SDA low. The block never drives the bus clock. For simulation, a parameter shrinks the storage depth. Each bank keeps its own half of the shrunken store.

Top module: `bank2_i2c_mem`

## Requirements
- R1: While reset is high and on the first cycle after it, `sda_oe` is 0 and the block waits for a Start.
- R2: The device byte is `1010`, A2, A1, bank, R/W from bit 7 down to bit 0, with A2 compared to `sel_pins[1]` and A1 to `sel_pins[0]`. On a match the block pulls SDA low in the ninth clock. On any mismatch it gives no acknowledge and ignores all bits until the next Start.
- R3: Bit 1 of the device byte becomes address bit 15. The same 15-bit offset in bank 0 and bank 1 holds independent data.
- R4: After a write device byte, the master sends the high address byte and then the low address byte. Bit 7 of the high byte has no effect.
- R5: Each data byte after the two address bytes is acknowledged and stored at the counter address. The write happens while SCL is low.
- R6: The 16-bit counter moves up by one after each data byte, written or read, and wraps from 0xFFFF to 0x0000.
- R7: A write device byte and two address bytes, followed by a repeated Start and a read device byte, return the byte stored at that address.
- R8: During a read the block drives each bit MSB first while SCL is low. It releases SDA for the master's acknowledge. A master ACK (SDA low) continues with the next byte. A NACK (SDA high) ends the read, after which no clocks move SDA until a Start. A Start always releases SDA.
- R9: A read device byte that follows a new Start without an address phase continues from the counter. Bits 14..0 come from the counter and bit 15 from the device byte.
- R10: A device byte sent straight after the Stop that ended a write is acknowledged, and the written byte reads back.
- R11: `sda_oe` only asserts while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| sel_pins | input | 2 | Device-select straps: [1] is A2, [0] is A1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A table of eight location and value pairs is written as single-byte writes across both banks, with several pairs sharing an offset. It is then read back by random reads, which separates bank selection from plain offset decoding. Directed patterns follow:
- a burst of four writes read back both singly and as one acknowledged sequence, which separates counter stepping from fixed addressing;
- a write across 0xFFFF, which shows the wrap;
- a high address byte with bit 7 set;
- a current-address read;
- device bytes with a wrong select pin or family code;
- clocks sent after a NACK.

The last two patterns must leave SDA untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int ADDR_W   = 16;
  localparam int BANK_BIT = ADDR_W - 1;
  localparam int HI_W     = BANK_BIT - 8;
  localparam logic [3:0] FAMILY = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } phase_t;
endpackage

// File: rtl/i2cm_linesync.sv
module i2cm_linesync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_N-1];
      sda_d  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_N-1];
  assign sda_s     = sda_ff[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem [DEPTH];
  logic [MEM_AW-1:0] widx, ridx;

  generate
    if (MEM_AW == ADDR_W) begin : g_full
      assign widx = waddr;
      assign ridx = raddr;
    end else begin : g_fold
      logic unused_mid;
      assign widx = {waddr[ADDR_W-1], waddr[MEM_AW-2:0]};
      assign ridx = {raddr[ADDR_W-1], raddr[MEM_AW-2:0]};
      assign unused_mid = ^{waddr[ADDR_W-2:MEM_AW-1], raddr[ADDR_W-2:MEM_AW-1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [1:0]        sel,
  input  logic [7:0]        rd_byte,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] cur_addr,
  output phase_t            phase
);
  phase_t            st;
  logic [3:0]        bitn;
  logic [7:0]        sh;
  logic              ack_slot;
  logic              rd_nack;
  logic [ADDR_W-1:0] addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PH_IDLE;
      bitn     <= '0;
      sh       <= '0;
      ack_slot <= 1'b0;
      rd_nack  <= 1'b0;
      addr     <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st       <= PH_DEV;
        bitn     <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        st       <= PH_IDLE;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (st != PH_IDLE) begin
        if (scl_rise) begin
          if (ack_slot) begin
            rd_nack <= sda_s;
          end else if (bitn != 4'd8) begin
            bitn <= bitn + 4'd1;
            if (st != PH_RD) sh <= {sh[6:0], sda_s};
          end
        end else if (scl_fall) begin
          if (ack_slot) begin
            // end of the ninth clock
            ack_slot <= 1'b0;
            bitn     <= '0;
            if (st == PH_RD) begin
              if (rd_nack) begin
                st     <= PH_IDLE;
                sda_oe <= 1'b0;
              end else begin
                sh     <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (bitn == 4'd8) begin
            unique case (st)
              PH_DEV: begin
                if (sh[7:4] == FAMILY && sh[3:2] == sel) begin
                  ack_slot       <= 1'b1;
                  sda_oe         <= 1'b1;
                  addr[BANK_BIT] <= sh[1];
                  st             <= sh[0] ? PH_RD : PH_AHI;
                end else begin
                  st <= PH_IDLE;
                end
              end
              PH_AHI: begin
                ack_slot             <= 1'b1;
                sda_oe               <= 1'b1;
                addr[BANK_BIT-1:8]   <= sh[HI_W-1:0];
                st                   <= PH_ALO;
              end
              PH_ALO: begin
                ack_slot   <= 1'b1;
                sda_oe     <= 1'b1;
                addr[7:0]  <= sh;
                st         <= PH_WR;
              end
              PH_WR: begin
                ack_slot <= 1'b1;
                sda_oe   <= 1'b1;
                wr_en    <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= sh;
                addr     <= addr + ADDR_W'(1);
              end
              PH_RD: begin
                ack_slot <= 1'b1;
                sda_oe   <= 1'b0;
                addr     <= addr + ADDR_W'(1);
              end
              default: st <= PH_IDLE;
            endcase
          end else if (st == PH_RD) begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
        end
      end
    end
  end

  assign cur_addr = addr;
  assign phase    = st;
endmodule

// File: rtl/bank2_i2c_mem.sv
module bank2_i2c_mem
  import i2cm_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] sel_pins,
  output logic       sda_oe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, cur_addr;
  logic [7:0]        wr_data, rd_byte;
  phase_t            phase;

  i2cm_linesync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .sel(sel_pins), .rd_byte(rd_byte), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur_addr(cur_addr), .phase(phase)
  );

  i2cm_store #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(cur_addr), .rdata(rd_byte)
  );
endmodule

// File: rtl/bank2_i2c_mem_chk.sv
module bank2_i2c_mem_chk
  import i2cm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              start_det,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input phase_t            phase
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!sda_oe && phase == PH_IDLE));

  // R11
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R6
  counter_step_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (cur_addr == wr_addr + ADDR_W'(1)));

  // R5
  write_low_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !scl_s);
endmodule

bind bank2_i2c_mem bank2_i2c_mem_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .wr_en(wr_en), .wr_addr(wr_addr),
  .cur_addr(cur_addr), .phase(phase)
);

// File: tb/sim_bank2_i2c_mem.sv
`timescale 1ns/1ps
module sim_bank2_i2c_mem;
  localparam int Q = 10;
  localparam logic [1:0] SEL = 2'b10;
  // {bank, offset[14:0], data}
  localparam logic [23:0] VEC [8] = '{
    24'h00005A, 24'h8000A5, 24'h01233C, 24'h8123C3,
    24'h7F0001, 24'h80FFFF, 24'h005500, 24'h923481
  };

  logic clk = 0;
  logic rst = 1;
  logic scl = 1;
  logic m_sda = 1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_err = 0, oe_bad = 0, oe_cyc = 0;
  logic oe_prev = 0;
  logic ok, ack;
  logic [7:0] d;
  int mark;
  bit done = 0;

  always #2.5 clk = ~clk;

  bank2_i2c_mem u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sel_pins(SEL), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    if (!rst && sda_oe && !oe_prev && scl) oe_bad++;
    if (sda_oe) oe_cyc++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] dev(input logic bank, input logic rd);
    return {4'b1010, SEL, bank, rd};
  endfunction

  task automatic bus_start;
    m_sda = 1; tick(Q); scl = 1; tick(Q); m_sda = 0; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 0; tick(Q); scl = 1; tick(Q); m_sda = 1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    end
    m_sda = 1; tick(Q); scl = 1; tick(Q); a = ~sda_line; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1; tick(Q); b[i] = sda_line; tick(Q); scl = 0;
    end
    m_sda = last; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); m_sda = 1;
  endtask

  task automatic set_addr(input logic [15:0] a, output logic good);
    logic a1, a2, a3;
    bus_start;
    send_byte(dev(a[15], 1'b0), a1);
    send_byte({1'b0, a[14:8]}, a2);
    send_byte(a[7:0], a3);
    good = a1 & a2 & a3;
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] v, output logic good);
    logic g, a4;
    set_addr(a, g);
    send_byte(v, a4);
    bus_stop;
    good = g & a4;
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] v);
    logic g, a4;
    set_addr(a, g);
    bus_start;
    send_byte(dev(a[15], 1'b1), a4);
    recv_byte(1'b1, v);
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim;
    end
  end

  initial begin
    tick(10);
    chk("R1 oe during reset", sda_oe, 0);
    rst = 0;
    tick(2);
    chk("R1 oe after reset", sda_oe, 0);

    // R3 R5 R7: table of single writes, then random reads
    for (int i = 0; i < 8; i++) begin
      write1(VEC[i][23:8], VEC[i][7:0], ok);
      chk("R5 write acked", ok, 1);
    end
    for (int i = 0; i < 8; i++) begin
      read1(VEC[i][23:8], d);
      chk("R3 R7 readback", d, VEC[i][7:0]);
    end

    // R2: wrong select pin, then wrong family code
    mark = oe_cyc;
    bus_start;
    send_byte({4'b1010, 2'b01, 1'b0, 1'b0}, ack);
    chk("R2 select mismatch nack", ack, 0);
    send_byte(8'h00, ack);
    chk("R2 ignored after mismatch", ack, 0);
    bus_stop;
    bus_start;
    send_byte({4'b1011, SEL, 1'b0, 1'b0}, ack);
    chk("R2 family mismatch nack", ack, 0);
    bus_stop;
    chk("R2 sda never pulled", oe_cyc - mark, 0);

    // R4: bit 7 of high address byte ignored
    bus_start;
    send_byte(dev(1'b0, 1'b0), ack);
    send_byte(8'h81, ack);
    send_byte(8'h11, ack);
    send_byte(8'h77, ack);
    bus_stop;
    read1(16'h0111, d);
    chk("R4 high bit ignored", d, 8'h77);

    // R5 R6: sequential write
    set_addr(16'h0040, ok);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'h10 * (i + 1), ack);
      chk("R5 burst byte acked", ack, 1);
    end
    bus_stop;
    read1(16'h0040, d);
    chk("R6 burst first byte", d, 8'h10);

    // R9: current address read after reading 0x0040
    bus_start;
    send_byte(dev(1'b0, 1'b1), ack);
    chk("R9 read device ack", ack, 1);
    recv_byte(1'b1, d);
    bus_stop;
    chk("R9 current address", d, 8'h20);

    // R8: sequential read with NACK on last, then clocks ignored
    set_addr(16'h0040, ok);
    bus_start;
    send_byte(dev(1'b0, 1'b1), ack);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i == 3, d);
      chk("R8 sequential read", d, 8'h10 * (i + 1));
    end
    mark = oe_cyc;
    send_byte(8'h00, ack);
    chk("R8 no ack after nack", ack, 0);
    chk("R8 sda idle after nack", oe_cyc - mark, 0);
    bus_stop;

    // R6: wrap from 0xFFFF to 0x0000
    set_addr(16'hFFFF, ok);
    send_byte(8'hE1, ack);
    send_byte(8'hE2, ack);
    bus_stop;
    read1(16'hFFFF, d);
    chk("R6 last location", d, 8'hE1);
    read1(16'h0000, d);
    chk("R6 wrapped to zero", d, 8'hE2);

    // R10: no busy window after a write
    write1(16'h8300, 8'h6D, ok);
    bus_start;
    send_byte(dev(1'b1, 1'b0), ack);
    chk("R10 ack right after write", ack, 1);
    send_byte(8'h03, ack);
    send_byte(8'h00, ack);
    bus_start;
    send_byte(dev(1'b1, 1'b1), ack);
    recv_byte(1'b1, d);
    bus_stop;
    chk("R10 data present", d, 8'h6D);

    chk("R11 oe rise only with scl low", oe_bad, 0);
    done = 1;
    finish_sim;
  end
endmodule